// File: doc/BRIEF.md
# ADC Conversion Start and Busy Sequencer

This block is the digital control core of a successive-approximation converter. A conversion can be requested in two ways: a rising edge on a hardware start pin, or a software write that sets a start bit. On the request the block puts the track/hold into hold and raises `busy`. It then waits for a falling edge of the conversion clock that comes late enough after the request to meet a setup window. From that edge it counts a fixed number of conversion-clock half periods. When the count ends, `busy` drops, the track/hold returns to track, and the comparator word from the analog side is latched onto a parallel read port.

The block runs on a system clock at twice the conversion-clock rate. It generates the conversion clock itself by toggling a register, so every half period is one system cycle.

The first request after reset starts a self-calibration instead of a conversion. Calibration holds `busy` high for a fixed time and produces no result. After each conversion an acquisition window follows. Requests that arrive while the block is occupied, or during that window, are dropped and recorded in a sticky flag.

Top module: `adc_conv_sequencer`

## Requirements
- R1: A rising edge on `start_pin`, or a cycle with `wr_en` and `wr_start` both high, is a start request. A write with `wr_start` low is not a request. An accepted request sets `busy` in the following cycle.
- R2: A conversion begins on the first system edge at which `cclk` is 1 (a conversion-clock falling edge) and which is at least `SETUP_CYC` edges after the edge that accepted the request. `busy` stays high from the accepting edge until `CONV_HALF` edges after that beginning edge. A missed setup window therefore adds one whole conversion-clock period.
- R3: At the edge where a conversion ends, `rd_data` takes the value of `sar_word`, `data_valid` becomes 1 and `hold` returns to 0. `hold` is 1 only while `busy` is 1.
- R4: An accepted write request makes `sw_start` read 1. `sw_start` returns to 0 at the edge where `busy` falls.
- R5: The first request after reset runs a calibration. During calibration `busy` is high for 2·`CAL_PERIODS` cycles and `hold` stays 0. Calibration leaves `rd_data` and `data_valid` unchanged and ends in idle.
- R6: For `ACQ_HALF` edges after the edge where a conversion's `busy` falls, requests are ignored and set `overrun`. A request one edge later is accepted.
- R7: A request while `busy` is high is ignored: the `busy` length is unchanged and `overrun` is set. `overrun` is sticky until reset.
- R8: A read (`rd_en`) while `busy` is high sets the sticky flag `rd_conflict`. `rd_data` keeps the previous result while `busy` is high.
- R9: A read clears `data_valid` at the next edge, unless a conversion ends at that same edge.
- R10: After reset, `busy`, `hold`, `sw_start`, `data_valid`, `overrun`, `rd_conflict`, `cclk` and `rd_data` are all 0.
- R11: `cclk` inverts on every system clock edge out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the conversion-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pin | input | 1 | Hardware conversion start; its rising edge is a request |
| wr_en | input | 1 | Control write strobe |
| wr_start | input | 1 | Start bit of the control write |
| rd_en | input | 1 | Result read strobe |
| sar_word | input | DATA_W | Comparator result word from the analog side |
| cclk | output | 1 | Generated conversion clock |
| hold | output | 1 | Track/hold in hold mode |
| busy | output | 1 | Conversion or calibration in progress |
| sw_start | output | 1 | Software start bit readback |
| rd_data | output | DATA_W | Last conversion result |
| data_valid | output | 1 | An unread result is present |
| overrun | output | 1 | Sticky: a request was dropped |
| rd_conflict | output | 1 | Sticky: a read happened during busy |

## Verification
The assertions assume that `start_pin`, `wr_en`, `wr_start` and `rd_en` are synchronous to `clk`; the block itself provides no synchronizer. They also assume that `sar_word` is valid at the edge where a conversion ends. The stimulus drives every input one time unit after a rising edge and holds the analog word steady for the whole of each conversion. The sweep applies requests from both sources at each conversion-clock phase, so the setup window is both met and missed. The expected `busy` length for each request is computed from the observed `cclk` phase and the setup rule.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAL,
        ST_ARM,
        ST_CONV,
        ST_ACQ
    } seq_state_e;

endpackage

// File: rtl/adc_start_detect.sv
module adc_start_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic start_pin,
    input  logic wr_en,
    input  logic wr_start,
    output logic req,
    output logic req_sw
);
    logic pin_d, pin_q;

    always_comb begin
        pin_d  = start_pin;
        req_sw = wr_en & wr_start;
        req    = (start_pin & ~pin_q) | req_sw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end
endmodule

// File: rtl/adc_cclk_gen.sv
module adc_cclk_gen (
    input  logic clk,
    input  logic rst_n,
    output logic cclk,
    output logic fall_now
);
    logic phase_d, phase_q;

    always_comb begin
        phase_d  = ~phase_q;
        cclk     = phase_q;
        // the edge that takes a high conversion clock low is a falling edge
        fall_now = phase_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/adc_setup_timer.sv
module adc_setup_timer #(
    parameter int SETUP_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic met
);
    localparam int CW = $clog2(SETUP_CYC + 1) + 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        met = (cnt_q + CW'(1)) >= CW'(SETUP_CYC);
        if (clr)
            cnt_d = '0;
        else if (cnt_q >= CW'(SETUP_CYC))
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer #(
    parameter int DATA_W      = 12,
    parameter int SETUP_CYC   = 1,
    parameter int CONV_HALF   = 33,
    parameter int ACQ_HALF    = 3,
    parameter int CAL_PERIODS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pin,
    input  logic              wr_en,
    input  logic              wr_start,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] sar_word,
    output logic              cclk,
    output logic              hold,
    output logic              busy,
    output logic              sw_start,
    output logic [DATA_W-1:0] rd_data,
    output logic              data_valid,
    output logic              overrun,
    output logic              rd_conflict
);
    import adc_seq_pkg::*;

    localparam int CAL_HALF = 2 * CAL_PERIODS;
    localparam int MAX_A    = (CAL_HALF > CONV_HALF) ? CAL_HALF : CONV_HALF;
    localparam int MAX_CNT  = (MAX_A > ACQ_HALF) ? MAX_A : ACQ_HALF;
    localparam int CNT_W    = $clog2(MAX_CNT + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic              hold;
        logic              sw;
        logic              cal_done;
        logic              valid;
        logic              ovr;
        logic              rdc;
        logic [DATA_W-1:0] res;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st: ST_IDLE, cnt: '0, busy: 1'b0, hold: 1'b0, sw: 1'b0,
        cal_done: 1'b0, valid: 1'b0, ovr: 1'b0, rdc: 1'b0, res: '0
    };

    seq_t s_d, s_q;
    logic req, req_sw, fall_now, setup_met, arm_clr;

    adc_start_detect i_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_pin (start_pin),
        .wr_en     (wr_en),
        .wr_start  (wr_start),
        .req       (req),
        .req_sw    (req_sw)
    );

    adc_cclk_gen i_cclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .cclk     (cclk),
        .fall_now (fall_now)
    );

    adc_setup_timer #(.SETUP_CYC(SETUP_CYC)) i_setup (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (arm_clr),
        .met   (setup_met)
    );

    always_comb begin
        s_d     = s_q;
        arm_clr = 1'b0;

        if (rd_en) begin
            s_d.valid = 1'b0;
            if (s_q.busy) s_d.rdc = 1'b1;
        end

        if (req && s_q.st != ST_IDLE) s_d.ovr = 1'b1;

        case (s_q.st)
            ST_IDLE: begin
                if (req) begin
                    s_d.busy = 1'b1;
                    if (req_sw) s_d.sw = 1'b1;
                    if (!s_q.cal_done) begin
                        s_d.st  = ST_CAL;
                        s_d.cnt = CNT_W'(CAL_HALF - 1);
                    end else begin
                        s_d.st   = ST_ARM;
                        s_d.hold = 1'b1;
                        arm_clr  = 1'b1;
                    end
                end
            end
            ST_CAL: begin
                if (s_q.cnt == '0) begin
                    s_d.st       = ST_IDLE;
                    s_d.busy     = 1'b0;
                    s_d.sw       = 1'b0;
                    s_d.cal_done = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_ARM: begin
                if (fall_now && setup_met) begin
                    s_d.st  = ST_CONV;
                    s_d.cnt = CNT_W'(CONV_HALF - 1);
                end
            end
            ST_CONV: begin
                if (s_q.cnt == '0) begin
                    s_d.st    = ST_ACQ;
                    s_d.cnt   = CNT_W'(ACQ_HALF - 1);
                    s_d.busy  = 1'b0;
                    s_d.hold  = 1'b0;
                    s_d.sw    = 1'b0;
                    s_d.res   = sar_word;
                    s_d.valid = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_ACQ: begin
                if (s_q.cnt == '0) s_d.st = ST_IDLE;
                else               s_d.cnt = s_q.cnt - CNT_W'(1);
            end
            default: s_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RST;
        else        s_q <= s_d;
    end

    always_comb begin
        hold        = s_q.hold;
        busy        = s_q.busy;
        sw_start    = s_q.sw;
        rd_data     = s_q.res;
        data_valid  = s_q.valid;
        overrun     = s_q.ovr;
        rd_conflict = s_q.rdc;
    end
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cclk,
    input logic              hold,
    input logic              busy,
    input logic              sw_start,
    input logic [DATA_W-1:0] rd_data,
    input logic              data_valid,
    input logic              overrun
);
    // R11: the conversion clock inverts on every edge out of reset
    a_r11_cclk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cclk != $past(cclk)));

    // R3: hold is only asserted inside a busy interval
    a_r3_hold_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> busy);

    // R3: the end of a conversion presents a valid result
    a_r3_valid_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> data_valid);

    // R4: the software start bit is clear once busy has fallen
    a_r4_sw_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !sw_start);

    // R8: the result port holds steady during busy
    a_r8_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && busy) |-> $stable(rd_data));

    // R6: no new busy in the cycle after a conversion ends
    a_r6_acq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |=> !busy);

    // R7: the overrun flag never clears out of reset
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(overrun)) |-> overrun);
endmodule

bind adc_conv_sequencer adc_seq_checker #(.DATA_W(DATA_W)) i_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cclk       (cclk),
    .hold       (hold),
    .busy       (busy),
    .sw_start   (sw_start),
    .rd_data    (rd_data),
    .data_valid (data_valid),
    .overrun    (overrun)
);

// File: tb/test_adc_conv_sequencer.sv
module test_adc_conv_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 12;
    localparam int SETUP_CYC  = 2;
    localparam int CONV_HALF  = 33;
    localparam int ACQ_HALF   = 3;
    localparam int CAL_PER    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_pin = 1'b0, wr_en = 1'b0, wr_start = 1'b0, rd_en = 1'b0;
    logic [DATA_W-1:0] sar_word = '0;
    logic cclk, hold, busy, sw_start, data_valid, overrun, rd_conflict;
    logic [DATA_W-1:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    adc_conv_sequencer #(
        .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC), .CONV_HALF(CONV_HALF),
        .ACQ_HALF(ACQ_HALF), .CAL_PERIODS(CAL_PER)
    ) i_adc_conv_sequencer (
        .clk(clk), .rst_n(rst_n), .start_pin(start_pin), .wr_en(wr_en),
        .wr_start(wr_start), .rd_en(rd_en), .sar_word(sar_word), .cclk(cclk),
        .hold(hold), .busy(busy), .sw_start(sw_start), .rd_data(rd_data),
        .data_valid(data_valid), .overrun(overrun), .rd_conflict(rd_conflict)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=%0d exp<150000", cyc);
            finish_run();
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // first accepting-edge offset k >= SETUP_CYC where cclk is high before that edge
    function automatic int exp_wait(logic ph0);
        for (int k = SETUP_CYC; k < SETUP_CYC + 4; k++)
            if ((ph0 ^ k[0]) == 1'b1) return k;
        return -1;
    endfunction

    // request issued before the next edge; returns with busy observed after that edge
    task automatic issue(int src);
        if (src == 0) start_pin = 1'b1;
        else begin wr_en = 1'b1; wr_start = 1'b1; end
        tick();
        start_pin = 1'b0; wr_en = 1'b0; wr_start = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            tick();
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic do_cal();
        int n;
        issue(0);
        check("R5 cal hold low", hold, 0);
        count_busy(n);
        check("R5 cal busy length", n, 2 * CAL_PER);
        check("R5 cal no valid", data_valid, 0);
        check("R5 cal no result", rd_data, 0);
        repeat (2) tick();
    endtask

    initial begin
        int n;
        int c0;
        int k;
        logic ph0;
        logic [DATA_W-1:0] prev;

        do_reset();
        // R10 reset values
        check("R10 busy", busy, 0);
        check("R10 hold", hold, 0);
        check("R10 sw_start", sw_start, 0);
        check("R10 data_valid", data_valid, 0);
        check("R10 overrun", overrun, 0);
        check("R10 rd_conflict", rd_conflict, 0);
        check("R10 rd_data", rd_data, 0);
        c0 = cclk;
        tick();
        check("R11 cclk inverts", cclk, c0 ^ 1);

        // R1: write with start bit clear is not a request
        wr_en = 1'b1; wr_start = 1'b0;
        tick();
        wr_en = 1'b0;
        tick();
        check("R1 no request without start bit", busy, 0);

        do_cal();

        // R2 sweep over source and phase
        for (int src = 0; src < 2; src++) begin
            for (int d = 0; d < 4; d++) begin
                repeat (ACQ_HALF + 1 + d) tick();
                sar_word = DATA_W'(src * 1237 + d * 331 + 5);
                ph0 = cclk;
                k = exp_wait(ph0);
                issue(src);
                check("R1 busy after request", busy, 1);
                check("R3 hold during conversion", hold, 1);
                if (src == 1) check("R4 sw_start set", sw_start, 1);
                count_busy(n);
                check("R2 busy length", n, k + CONV_HALF);
                check("R3 result latched", rd_data, int'(sar_word));
                check("R3 valid", data_valid, 1);
                check("R3 hold released", hold, 0);
                check("R4 sw_start cleared", sw_start, 0);
                check("R7 no spurious overrun", overrun, 0);
            end
        end

        // R9: read in idle clears valid
        repeat (ACQ_HALF + 1) tick();
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        check("R9 read clears valid", data_valid, 0);
        check("R8 idle read no conflict", rd_conflict, 0);

        // R8: read during busy
        prev = rd_data;
        sar_word = 12'hA5C;
        issue(0);
        tick();
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        check("R8 conflict flag", rd_conflict, 1);
        check("R8 old result kept", rd_data, int'(prev));
        count_busy(n);
        check("R3 new result after read", rd_data, 12'hA5C);
        check("R9 valid set at end", data_valid, 1);

        // R6: acquisition window boundary
        tick();                     // now after Eb+1 edge; next edges Eb+2, Eb+3
        tick();
        wr_en = 1'b1; wr_start = 1'b1;
        tick();                     // edge Eb+3: still acquisition
        check("R6 ignored in window", busy, 0);
        check("R6 overrun set", overrun, 1);
        tick();                     // edge Eb+4: accepted
        wr_en = 1'b0; wr_start = 1'b0;
        check("R6 accepted after window", busy, 1);
        count_busy(n);
        check("R6 result after window", data_valid, 1);

        // R7: request during busy after a fresh reset
        do_reset();
        do_cal();
        ph0 = cclk;
        k = exp_wait(ph0);
        sar_word = 12'h3C1;
        issue(1);
        n = 1;
        repeat (5) begin tick(); n++; end
        start_pin = 1'b1;
        tick(); n++;
        start_pin = 1'b0;
        check("R7 overrun on busy request", overrun, 1);
        begin
            int rest;
            count_busy(rest);
            n = n + rest - 1;
        end
        check("R7 busy length unchanged", n, k + CONV_HALF);
        check("R7 result", rd_data, 12'h3C1);
        check("R7 overrun sticky", overrun, 1);

        finish_run();
    end
endmodule